// File: doc/BRIEF.md
# Serial-Load Channel Driver with Level Latch

This block is the digital core of a multi-channel output driver that is loaded over a serial line. Bits enter on a data pin and are shifted in on each rising edge of a serial clock. A copy of the final shift stage appears on a cascade pin, so several drivers can be chained one after another on the same serial clock.

A level-sensitive latch sits between the shift chain and the channel outputs. While the latch control is high, the latch passes the shift contents straight through, so the channels follow every shift. While it is low, the channels keep the pattern they had when the control fell. An active-low enable blanks all channels without disturbing the latch. A latched 1 turns a channel on (output high). An active-low asynchronous reset clears both the shift chain and the latch.

Top module: `sipo_latch_driver`

## Requirements
- R1: On each rising edge of `ser_clk`, shift stage 0 takes `ser_in` and each stage k (k >= 1) takes the old value of stage k-1.
- R2: With the latch transparent and the enable active, `chan_out[k]` equals the bit shifted in k edges before the most recent edge, so bit 0 is the newest.
- R3: `ser_out` always shows the last shift stage: the bit shifted in N-1 edges before the most recent edge.
- R4: While `lat_en` is high, the channels follow the shift chain at once after every shift and after `lat_en` rises. No further control edge is needed.
- R5: While `lat_en` is low, the channels keep the value captured when `lat_en` fell, whatever is shifted.
- R6: While `oe_n` is high, all channels are 0. When it returns low, the latched pattern reappears unchanged.
- R7: Without a rising edge of `ser_clk`, changes on `ser_in` leave `ser_out` and the channels unchanged.
- R8: Driving `rst_n` low clears the shift chain and the latch to all zeros at once, with no clock edge. The channels and `ser_out` then read 0 whatever the level of `oe_n` and `lat_en`.
- R9: Parameter N (default 16, minimum 2) sets the channel count and the shift depth, and the cascade pin is stage N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data input |
| lat_en | input | 1 | Latch control, transparent while high |
| oe_n | input | 1 | Output enable, active low; high blanks all channels |
| ser_out | output | 1 | Cascade output, last shift stage |
| chan_out | output | N | Channel outputs, 1 = on |

## Verification
The bench builds the block with N = 8. With that size, every one of the 256 possible register patterns can be shifted in with the latch closed and then released through it, so each bit-to-channel mapping and each cascade value is checked. The small depth also allows the transparent mode to be followed shift by shift over a whole pattern. It keeps blanking, clock-less input activity and a reset in the middle of a pattern short, so each is checked against a shadow model kept in the bench.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;
   // smallest legal chain: stage N-1 must differ from stage 0
   localparam int unsigned SIPO_MIN_CH = 2;

   function automatic logic [0:0] chan_drive(input logic bit_q, input logic oe_n);
      return bit_q & ~oe_n;
   endfunction
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
   parameter int unsigned N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_in,
   output logic [N-1:0] q
);
   localparam int unsigned TOP = N - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= {q[TOP-1:0], d_in};
   end
endmodule

// File: rtl/sipo_level_latch.sv
module sipo_level_latch #(
   parameter int unsigned N = 16
) (
   input  logic         rst_n,
   input  logic         open_i,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   always_latch begin
      if (!rst_n)      q <= '0;
      else if (open_i) q <= d;
   end
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
   parameter int unsigned N = 16
) (
   input  logic         oe_n,
   input  logic [N-1:0] held,
   output logic [N-1:0] drive
);
   import sipo_drv_pkg::*;

   for (genvar k = 0; k < N; k++) begin : g_ch
      assign drive[k] = chan_drive(held[k], oe_n);
   end
endmodule

// File: rtl/sipo_latch_driver.sv
module sipo_latch_driver #(
   parameter int unsigned N = 16
) (
   input  logic         ser_clk,
   input  logic         rst_n,
   input  logic         ser_in,
   input  logic         lat_en,
   input  logic         oe_n,
   output logic         ser_out,
   output logic [N-1:0] chan_out
);
   import sipo_drv_pkg::*;

   localparam int unsigned LAST = N - 1;

   if (N < SIPO_MIN_CH) begin : g_bad_n
      $fatal(1, "sipo_latch_driver: N must be at least %0d", SIPO_MIN_CH);
   end

   logic [N-1:0] sr_q;
   logic [N-1:0] lat_q;

   sipo_shift_chain #(.N(N)) u_chain (
      .clk   (ser_clk),
      .rst_n (rst_n),
      .d_in  (ser_in),
      .q     (sr_q)
   );

   sipo_level_latch #(.N(N)) u_latch (
      .rst_n  (rst_n),
      .open_i (lat_en),
      .d      (sr_q),
      .q      (lat_q)
   );

   sipo_out_gate #(.N(N)) u_gate (
      .oe_n  (oe_n),
      .held  (lat_q),
      .drive (chan_out)
   );

   assign ser_out = sr_q[LAST];
endmodule

// File: rtl/sipo_latch_driver_chk.sv
module sipo_latch_driver_chk #(
   parameter int unsigned N = 16
) (
   input logic         ser_clk,
   input logic         rst_n,
   input logic         ser_in,
   input logic         lat_en,
   input logic         oe_n,
   input logic         ser_out,
   input logic [N-1:0] chan_out,
   input logic [N-1:0] sr_q
);
   // set by any reset, cleared by the next shift edge
   logic rst_seen;
   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n) rst_seen <= 1'b1;
      else        rst_seen <= 1'b0;
   end

   a_r1_shift_entry: assert property (@(posedge ser_clk) disable iff (!rst_n)
      !rst_seen |-> sr_q[0] == $past(ser_in));

   a_r1_shift_move: assert property (@(posedge ser_clk) disable iff (!rst_n)
      !rst_seen |-> sr_q[N-1:1] == $past(sr_q[N-2:0]));

   a_r3_cascade: assert property (@(posedge ser_clk) disable iff (!rst_n)
      !rst_seen |-> ser_out == $past(sr_q[N-2]));

   a_r6_blank: assert property (@(posedge ser_clk) disable iff (!rst_n)
      oe_n |-> chan_out == '0);

   a_r4_transparent: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (lat_en && !oe_n) |-> chan_out == sr_q);
endmodule

bind sipo_latch_driver sipo_latch_driver_chk #(.N(N)) u_chk (
   .ser_clk  (ser_clk),
   .rst_n    (rst_n),
   .ser_in   (ser_in),
   .lat_en   (lat_en),
   .oe_n     (oe_n),
   .ser_out  (ser_out),
   .chan_out (chan_out),
   .sr_q     (sr_q)
);

// File: tb/sim_sipo_latch_driver.sv
module sim_sipo_latch_driver;
   localparam int N = 8;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   logic gate = 1'b0;
   logic rst_n = 1'b0;
   logic ser_in = 1'b0;
   logic lat_en = 1'b1;
   logic oe_n = 1'b0;
   logic ser_out;
   logic [N-1:0] chan_out;
   wire ser_clk;

   always #5 clk = ~clk;
   assign ser_clk = clk & gate;

   sipo_latch_driver #(.N(N)) u0 (
      .ser_clk (ser_clk), .rst_n (rst_n), .ser_in (ser_in),
      .lat_en (lat_en), .oe_n (oe_n), .ser_out (ser_out), .chan_out (chan_out)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [N-1:0] m_sr = '0;
   logic [N-1:0] m_lat = '0;

   function automatic logic [N-1:0] exp_out();
      return oe_n ? '0 : m_lat;
   endfunction

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, expv);
      end
   endtask

   task automatic shift_bit(input logic b);
      @(negedge clk);
      ser_in = b;
      gate = 1'b1;
      @(negedge clk);
      gate = 1'b0;
      m_sr = {m_sr[N-2:0], b};
      if (lat_en) m_lat = m_sr;
      #1;
   endtask

   task automatic set_lat(input logic v);
      lat_en = v;
      if (v) m_lat = m_sr;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=under %0d", WATCHDOG, WATCHDOG);
      finish_run();
   end

   initial begin
      logic [N-1:0] pat;
      logic [N-1:0] snap;
      // reset state, latch open and enable active
      #12;
      check("R8 reset channels", chan_out, '0);
      check("R8 reset cascade", {{(N-1){1'b0}}, ser_out}, '0);
      oe_n = 1'b1; #1;
      check("R8 reset channels oe_n high", chan_out, '0);
      oe_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; #1;

      // transparent mode: channels follow every shift
      pat = 8'b1011_0010;
      for (int i = N - 1; i >= 0; i--) begin
         shift_bit(pat[i]);
         check("R4 follow shift", chan_out, exp_out());
         check("R3 cascade", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, m_sr[N-1]});
      end
      check("R2 mapping after full load", chan_out, pat);
      check("R1 chain content", chan_out, m_sr);

      // exhaustive load with latch closed, then release
      for (int p = 0; p < (1 << N); p++) begin
         set_lat(1'b0);
         snap = chan_out;
         pat = p[N-1:0];
         for (int i = N - 1; i >= 0; i--) shift_bit(pat[i]);
         check("R5 hold while closed", chan_out, snap);
         check("R9 cascade is stage N-1", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, pat[N-1]});
         set_lat(1'b1);
         check("R2 pattern through latch", chan_out, pat);
      end

      // blanking
      set_lat(1'b0);
      snap = chan_out;
      oe_n = 1'b1; #1;
      check("R6 blanked", chan_out, '0);
      shift_bit(1'b1);
      set_lat(1'b1);
      check("R6 blanked while transparent", chan_out, '0);
      set_lat(1'b0);
      oe_n = 1'b0; #1;
      check("R6 restore after blank", chan_out, m_lat);

      // no clock edge: serial input activity has no effect
      set_lat(1'b1);
      snap = chan_out;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         ser_in = ~ser_in;
         #2;
      end
      check("R7 channels without edge", chan_out, snap);
      check("R7 cascade without edge", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, m_sr[N-1]});

      // reset mid-pattern, latch closed, enable active
      for (int i = 0; i < N; i++) shift_bit(1'b1);
      set_lat(1'b0);
      check("R4 all ones loaded", chan_out, '1);
      #2 rst_n = 1'b0; #1;
      m_sr = '0; m_lat = '0;
      check("R8 async clear channels", chan_out, '0);
      check("R8 async clear cascade", {{(N-1){1'b0}}, ser_out}, '0);
      @(negedge clk); rst_n = 1'b1; #1;
      set_lat(1'b1);
      check("R8 chain empty after reset", chan_out, '0);
      shift_bit(1'b1);
      check("R1 first bit after reset", chan_out, {{(N-1){1'b0}}, 1'b1});

      finish_run();
   end
endmodule